// File: doc/BRIEF.md
# Two-Operand Integer Execute Unit

This unit is the integer execute stage of a small 16-bit RISC core with eight registers. It takes one 16-bit instruction word, the program counter and two operand values already read from the register file. In the same cycle it returns the destination register index, a write strobe and the value to write. The destination register is also the first operand, so the value on `src_a_i` is the current contents of the register named by bits [8:6]. The value on `src_b_i` is the register named by bits [11:9].

Only three instruction classes are executed here: register-register arithmetic, register-with-immediate arithmetic and the two upper-immediate forms. Any other format, and any undefined encoding inside the three classes, raises the reject flag. A rejected word never writes and drives a zero result, so a later stage can trap or hand the word to another unit. The unit holds no state.

Top module: `ieu_exec`

## Requirements
- R1: Bits [2:0] pick the class: 000 register-register, 001 register-immediate, 110 upper-immediate. Any other value sets `illegal_o`=1 and `wr_en_o`=0.
- R2: Register-register ops, coded as funct4 in [15:12] and func3 in [5:3], produce `src_a_i` op `src_b_i` modulo 2^16. The codes are add 0000/000, subtract 0001/000, OR 0111/100, AND 1000/101, XOR 1001/110 and move of `src_b_i` 1010/111.
- R3: Set-less-than returns 1 or 0. The signed register form is 0010/001 and the unsigned register form is 0011/010. The immediate forms use func3 001 (signed) and func3 010 (unsigned). The unsigned immediate form compares against the sign-extended immediate taken as unsigned.
- R4: Register shifts take their amount from `src_b_i`[3:0] only. The codes are left 0100/011, logical right 0101/011 and arithmetic right 0110/011.
- R5: Every funct4/func3 pair not listed in R2 to R4 gives `illegal_o`=1, `wr_en_o`=0 and `result_o`=0. The same holds for every rejected word.
- R6: Register-immediate ops sign-extend the 7-bit immediate in [15:9]. func3 000 adds, 100 ORs, 101 ANDs and 110 XORs it with `src_a_i`.
- R7: With func3 011, immediate bits [12:9] give the shift amount and bits [15:13] give the kind: 001 left, 010 logical right, 100 arithmetic right. Any other kind is rejected as in R5.
- R8: func3 111 in the register-immediate class writes the sign-extended immediate itself.
- R9: The upper-immediate value is {[14:9],[5:3]} shifted left by 7. Bit 15 = 0 writes that value. Bit 15 = 1 writes `pc_i` plus that value modulo 2^16.
- R10: `rd_o` always equals bits [8:6]. `wr_en_o` is the inverse of `illegal_o`.
- R11: The outputs follow the inputs combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Address of the instruction |
| src_a_i | input | 16 | Value of the destination/first-source register |
| src_b_i | input | 16 | Value of the second-source register |
| rd_o | output | 3 | Destination register index |
| wr_en_o | output | 1 | Write strobe for the destination |
| result_o | output | 16 | Value to write |
| illegal_o | output | 1 | Word not executed by this unit |

## Verification
The assertions check properties that must hold for every input combination:
- foreign opcodes and undefined shift kinds are rejected;
- a rejected word stays silent;
- the destination field passes straight through;
- compare results are only ever 0 or 1;
- the low seven bits of a plain upper-immediate result are zero;
- the load-immediate value is correct.

The exact arithmetic can only be shown by the bench's sweeps, which cover every instruction word under several operand sets. These include the sign boundaries of compares, subtraction and arithmetic shifts, and the program-counter wrap of the PC-relative upper form.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  localparam int ILEN   = 16;
  localparam int REG_W  = 3;
  localparam int IMM_W  = 7;
  localparam int UIMM_W = 9;
  localparam int USHIFT = 7;

  typedef enum logic [2:0] {
    CLS_REG   = 3'b000,
    CLS_IMM   = 3'b001,
    CLS_UPPER = 3'b110
  } cls_e;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA,
    OP_OR, OP_AND, OP_XOR, OP_PASSB
  } alu_op_e;

  typedef enum logic [1:0] { A_REG, A_PC, A_ZERO } a_sel_e;
  typedef enum logic [1:0] { B_REG, B_IMM, B_UPPER } b_sel_e;

  typedef struct packed {
    logic    legal;
    alu_op_e op;
    a_sel_e  a_sel;
    b_sel_e  b_sel;
  } ctl_t;
endpackage

// File: rtl/ieu_decode.sv
module ieu_decode
  import ieu_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output ctl_t            ctl_o
);
  logic [2:0] cls;
  logic [3:0] f4;
  logic [2:0] f3;
  logic [2:0] shkind;

  assign cls    = instr_i[2:0];
  assign f4     = instr_i[15:12];
  assign f3     = instr_i[5:3];
  assign shkind = instr_i[15:13];

  function automatic ctl_t reg_ctl(input logic [3:0] k4, input logic [2:0] k3);
    ctl_t c;
    c = '{legal: 1'b1, op: OP_ADD, a_sel: A_REG, b_sel: B_REG};
    unique case ({k4, k3})
      7'b0000_000: c.op = OP_ADD;
      7'b0001_000: c.op = OP_SUB;
      7'b0010_001: c.op = OP_SLT;
      7'b0011_010: c.op = OP_SLTU;
      7'b0100_011: c.op = OP_SLL;
      7'b0101_011: c.op = OP_SRL;
      7'b0110_011: c.op = OP_SRA;
      7'b0111_100: c.op = OP_OR;
      7'b1000_101: c.op = OP_AND;
      7'b1001_110: c.op = OP_XOR;
      7'b1010_111: c.op = OP_PASSB;
      default:     c.legal = 1'b0;
    endcase
    return c;
  endfunction

  function automatic ctl_t imm_ctl(input logic [2:0] k3, input logic [2:0] kind);
    ctl_t c;
    c = '{legal: 1'b1, op: OP_ADD, a_sel: A_REG, b_sel: B_IMM};
    unique case (k3)
      3'b000: c.op = OP_ADD;
      3'b001: c.op = OP_SLT;
      3'b010: c.op = OP_SLTU;
      3'b011: begin
        unique case (kind)
          3'b001:  c.op = OP_SLL;
          3'b010:  c.op = OP_SRL;
          3'b100:  c.op = OP_SRA;
          default: c.legal = 1'b0;
        endcase
      end
      3'b100: c.op = OP_OR;
      3'b101: c.op = OP_AND;
      3'b110: c.op = OP_XOR;
      default: c.op = OP_PASSB;
    endcase
    return c;
  endfunction

  always_comb begin
    unique case (cls)
      CLS_REG:   ctl_o = reg_ctl(f4, f3);
      CLS_IMM:   ctl_o = imm_ctl(f3, shkind);
      CLS_UPPER: ctl_o = '{legal: 1'b1, op: OP_ADD,
                          a_sel: (instr_i[15] ? A_PC : A_ZERO), b_sel: B_UPPER};
      default:   ctl_o = '{legal: 1'b0, op: OP_ADD, a_sel: A_ZERO, b_sel: B_REG};
    endcase
  end
endmodule

// File: rtl/ieu_operands.sv
module ieu_operands
  import ieu_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  a_sel_e          a_sel_i,
  input  b_sel_e          b_sel_i,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o
);
  localparam int SEXT_W = XLEN - IMM_W;

  logic [IMM_W-1:0]  imm7;
  logic [UIMM_W-1:0] uimm;
  logic [XLEN-1:0]   imm_sx;
  logic [XLEN-1:0]   upper_val;

  assign imm7      = instr_i[15:9];
  assign uimm      = {instr_i[14:9], instr_i[5:3]};
  assign imm_sx    = {{SEXT_W{imm7[IMM_W-1]}}, imm7};
  assign upper_val = XLEN'({uimm, {USHIFT{1'b0}}});

  always_comb begin
    unique case (a_sel_i)
      A_REG:   opa_o = src_a_i;
      A_PC:    opa_o = pc_i;
      default: opa_o = '0;
    endcase
    unique case (b_sel_i)
      B_REG:   opb_o = src_b_i;
      B_IMM:   opb_o = imm_sx;
      default: opb_o = upper_val;
    endcase
  end
endmodule

// File: rtl/ieu_alu.sv
module ieu_alu
  import ieu_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int SH_W = $clog2(XLEN);

  function automatic logic [XLEN-1:0] less_than(input logic [XLEN-1:0] x,
                                                input logic [XLEN-1:0] y,
                                                input logic is_signed);
    logic lt;
    lt = is_signed ? ($signed(x) < $signed(y)) : (x < y);
    return XLEN'(lt);
  endfunction

  function automatic logic [XLEN-1:0] shift(input logic [XLEN-1:0] x,
                                            input logic [SH_W-1:0] amt,
                                            input alu_op_e kind);
    unique case (kind)
      OP_SLL:  return x << amt;
      OP_SRL:  return x >> amt;
      default: return XLEN'($signed(x) >>> amt);
    endcase
  endfunction

  logic [SH_W-1:0] amt;
  assign amt = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_SLT:  y_o = less_than(a_i, b_i, 1'b1);
      OP_SLTU: y_o = less_than(a_i, b_i, 1'b0);
      OP_SLL, OP_SRL, OP_SRA: y_o = shift(a_i, amt, op_i);
      OP_OR:   y_o = a_i | b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/ieu_exec.sv
module ieu_exec
  import ieu_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [15:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [2:0]      rd_o,
  output logic            wr_en_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  ctl_t            ctl;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] alu_y;

  ieu_decode u_dec (
    .instr_i (instr_i),
    .ctl_o   (ctl)
  );

  ieu_operands #(.XLEN(XLEN)) u_opnd (
    .instr_i (instr_i),
    .pc_i    (pc_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .a_sel_i (ctl.a_sel),
    .b_sel_i (ctl.b_sel),
    .opa_o   (opa),
    .opb_o   (opb)
  );

  ieu_alu #(.XLEN(XLEN)) u_alu (
    .op_i (ctl.op),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (alu_y)
  );

  assign rd_o      = instr_i[8:6];
  assign wr_en_o   = ctl.legal;
  assign illegal_o = ~ctl.legal;
  assign result_o  = ctl.legal ? alu_y : '0;
endmodule

// File: rtl/ieu_exec_chk.sv
module ieu_exec_chk #(
  parameter int XLEN = 16
) (
  input logic [15:0]     instr_i,
  input logic [XLEN-1:0] result_o,
  input logic [2:0]      rd_o,
  input logic            wr_en_o,
  input logic            illegal_o
);
  logic [2:0] cls;
  logic [2:0] f3;
  logic       is_cmp;
  logic [XLEN-1:0] li_exp;

  assign cls    = instr_i[2:0];
  assign f3     = instr_i[5:3];
  assign is_cmp = ((cls == 3'b000) || (cls == 3'b001)) && ((f3 == 3'b001) || (f3 == 3'b010));
  assign li_exp = XLEN'($signed(instr_i[15:9]));

  always_comb begin
    if (!(cls == 3'b000 || cls == 3'b001 || cls == 3'b110))
      assert_foreign_rejected_R1: assert (illegal_o && !wr_en_o);
    if (illegal_o)
      assert_quiet_reject_R5: assert (result_o == '0 && !wr_en_o);
    assert_dest_field_R10: assert (rd_o == instr_i[8:6]);
    if (is_cmp && wr_en_o)
      assert_flag_boolean_R3: assert (result_o[XLEN-1:1] == '0);
    if (cls == 3'b001 && f3 == 3'b011 &&
        !(instr_i[15:13] == 3'b001 || instr_i[15:13] == 3'b010 || instr_i[15:13] == 3'b100))
      assert_shift_kind_R7: assert (illegal_o);
    if (cls == 3'b001 && f3 == 3'b111)
      assert_li_value_R8: assert (wr_en_o && result_o == li_exp);
    if (cls == 3'b110 && !instr_i[15])
      assert_upper_low_zero_R9: assert (wr_en_o && result_o[6:0] == '0);
  end
endmodule

bind ieu_exec ieu_exec_chk #(.XLEN(XLEN)) u_chk (
  .instr_i   (instr_i),
  .result_o  (result_o),
  .rd_o      (rd_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o)
);

// File: tb/ieu_exec_bench.sv
`timescale 1ns/100ps
module ieu_exec_bench;
  logic        clk = 1'b0;
  logic [15:0] instr, pc, sa, sb;
  logic [2:0]  rd;
  logic        we, ill;
  logic [15:0] res;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ieu_exec u_ieu_exec (
    .instr_i(instr), .pc_i(pc), .src_a_i(sa), .src_b_i(sb),
    .rd_o(rd), .wr_en_o(we), .result_o(res), .illegal_o(ill)
  );

  function automatic logic [15:0] sra16(input logic [15:0] x, input int s);
    logic [15:0] r;
    r = x >> s;
    if (x[15]) r = r | ~(16'hFFFF >> s);
    return r;
  endfunction

  function automatic logic slt16(input logic [15:0] x, input logic [15:0] y);
    return (x ^ 16'h8000) < (y ^ 16'h8000);
  endfunction

  function automatic void model(input logic [15:0] w, p, a, b,
                                output logic [15:0] er, output logic ew, output string tag);
    logic [15:0] imm;
    int s;
    er = 16'h0; ew = 1'b1; tag = "R1";
    imm = {{9{w[15]}}, w[15:9]};
    case (w[2:0])
      3'b000: begin
        s = int'(b[3:0]);
        case ({w[15:12], w[5:3]})
          7'b0000000: begin er = a + b; tag = "R2"; end
          7'b0001000: begin er = a + ~b + 16'd1; tag = "R2"; end
          7'b0111100: begin er = a | b; tag = "R2"; end
          7'b1000101: begin er = a & b; tag = "R2"; end
          7'b1001110: begin er = a ^ b; tag = "R2"; end
          7'b1010111: begin er = b; tag = "R2"; end
          7'b0010001: begin er = {15'd0, slt16(a, b)}; tag = "R3"; end
          7'b0011010: begin er = {15'd0, a < b}; tag = "R3"; end
          7'b0100011: begin er = a << s; tag = "R4"; end
          7'b0101011: begin er = a >> s; tag = "R4"; end
          7'b0110011: begin er = sra16(a, s); tag = "R4"; end
          default:    begin ew = 1'b0; tag = "R5"; end
        endcase
      end
      3'b001: begin
        s = int'(w[12:9]);
        tag = "R6";
        case (w[5:3])
          3'b000: er = a + imm;
          3'b001: begin er = {15'd0, slt16(a, imm)}; tag = "R3"; end
          3'b010: begin er = {15'd0, a < imm}; tag = "R3"; end
          3'b011: begin
            tag = "R7";
            if (w[15:13] == 3'b001) er = a << s;
            else if (w[15:13] == 3'b010) er = a >> s;
            else if (w[15:13] == 3'b100) er = sra16(a, s);
            else ew = 1'b0;
          end
          3'b100: er = a | imm;
          3'b101: er = a & imm;
          3'b110: er = a ^ imm;
          default: begin er = imm; tag = "R8"; end
        endcase
      end
      3'b110: begin
        tag = "R9";
        er = 16'({w[14:9], w[5:3]}) * 16'd128;
        if (w[15]) er = er + p;
      end
      default: ew = 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [15:0] w, p, a, b, input string force_tag);
    logic [15:0] er;
    logic ew;
    string tag;
    instr = w; pc = p; sa = a; sb = b;
    #0.5;
    model(w, p, a, b, er, ew, tag);
    if (force_tag != "") tag = force_tag;
    n_chk++;
    if (res !== er || we !== ew || ill !== !ew || rd !== w[8:6]) begin
      n_fail++;
      $display("FAIL %s instr=%h a=%h b=%h pc=%h: res=%h we=%b ill=%b rd=%0d expected res=%h we=%b ill=%b rd=%0d",
               tag, w, a, b, p, res, we, ill, rd, er, ew, !ew, w[8:6]);
    end
    #0.5;
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] f4, input logic [2:0] f3);
    return {f4, 3'd2, 3'd5, f3, 3'b000};
  endfunction
  function automatic logic [15:0] enc_i(input logic [6:0] im, input logic [2:0] f3);
    return {im, 3'd4, f3, 3'b001};
  endfunction

  initial begin
    instr = '0; pc = '0; sa = '0; sb = '0;
    #1.5;
    apply(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R10"); // idle state: add x0 gives 0
    apply(16'h0002, 16'h0000, 16'h1111, 16'h2222, "R1");  // branch class rejected
    apply(16'h0007, 16'h0000, 16'h1111, 16'h2222, "R1");
    apply(enc_r(4'b0001, 3'b000), 16'h0, 16'h8000, 16'h0001, "R2"); // 0x7FFF
    apply(enc_r(4'b0010, 3'b001), 16'h0, 16'h7FFF, 16'h8000, "R3"); // 0
    apply(enc_r(4'b0011, 3'b010), 16'h0, 16'h7FFF, 16'h8000, "R3"); // 1
    apply(enc_r(4'b0110, 3'b011), 16'h0, 16'h8000, 16'hFFFF, "R4"); // amt 15
    apply(enc_r(4'b0100, 3'b011), 16'h0, 16'h0001, 16'h0010, "R4"); // amt 0
    apply(enc_r(4'b1011, 3'b000), 16'h0, 16'h1234, 16'h5678, "R5"); // register jump rejected
    apply(enc_r(4'b0000, 3'b001), 16'h0, 16'h1234, 16'h5678, "R5");
    apply(enc_i(7'h40, 3'b000), 16'h0, 16'h0000, 16'h0, "R6");      // -64
    apply(enc_i(7'h7F, 3'b010), 16'h0, 16'hFFF0, 16'h0, "R3");      // unsigned vs 0xFFFF
    apply(enc_i(7'h4F, 3'b011), 16'h0, 16'h8000, 16'h0, "R7");      // sra 15
    apply(enc_i(7'h3F, 3'b011), 16'h0, 16'h8000, 16'h0, "R7");      // bad kind
    apply(enc_i(7'h41, 3'b111), 16'h0, 16'hAAAA, 16'h0, "R8");
    apply({1'b1, 6'h00, 3'd1, 3'b001, 3'b110}, 16'hFF80, 16'h0, 16'h0, "R9"); // pc wraps to 0
    apply({1'b0, 6'h3F, 3'd1, 3'b111, 3'b110}, 16'h1234, 16'h0, 16'h0, "R9"); // 0xFF80
    // R11: sweep every word with no clock involvement, several operand sets
    for (int k = 0; k < 4; k++) begin
      logic [15:0] a, b, p;
      case (k)
        0: begin a = 16'h7FFF; b = 16'h8000; p = 16'hFF80; end
        1: begin a = 16'h8000; b = 16'h7FFF; p = 16'h0002; end
        2: begin a = 16'hFFFF; b = 16'h0001; p = 16'h8000; end
        default: begin a = 16'h1234; b = 16'hC0DE; p = 16'h7FFE; end
      endcase
      for (int w = 0; w < 65536; w++) apply(16'(w), p, a, b, "");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule